// File: doc/BRIEF.md
# Multicast Event Packet Router

This block steers small event packets inside one node of a mesh of processing nodes. A packet has an 8-bit header, a routing key and, when the header says so, a payload word. The header names one of four packet kinds. Only multicast packets are routed here. Their key is looked up in a table of ternary entries. Each entry is a stored value, a compare mask, a destination bitmap and a valid bit. A hit returns a bitmap that can select any mix of outgoing inter-node links and local processor cores, so one packet is copied to every selected place in the same cycle. A miss sends the packet on one default link, the one facing away from the link it came in on.

Before any routing, every packet is checked. A packet with bad parity is thrown away and counted on a saturating error counter. A packet whose age stamp lags the node's time phase by two or more steps is thrown away silently, so a packet that loops cannot circulate forever. A healthy packet that is not multicast leaves on a separate bypass output, unchanged, for the other routing stages. The input uses a valid/ready handshake. A multicast packet is released only in a cycle where every destination it selects is ready, so no copy is ever lost. Table entries are loaded through a plain write port, and reset clears every valid bit.

The lookup and the fan-out decision are combinational from the input to the outputs. The only state is the table and the error counter.

Top module: `mcr_router`

## Requirements
- R1: Header bits: [7:6] kind (00 multicast, 01 point-to-point, 10 nearest-neighbour, 11 fixed-route), [5:4] age stamp, [1] payload present, [0] parity, [3:2] carry no meaning. A packet is parity-good when the XOR of the header, the key and, only when bit 1 is set, the payload is 0. When bit 1 is clear the payload value has no effect.
- R2: A table entry hits when its valid bit is set and the key equals the stored value in every position whose mask bit is 1. Mask bits of 0 are don't-care.
- R3: When several entries hit, the one with the lowest index supplies the route.
- R4: On a hit, `mc_dest` equals the entry's route bitmap. Bits [N_LINKS-1:0] select links, where bit k is link k. The bits above them select local cores.
- R5: On a miss, `mc_dest` has exactly one bit set: link (in_link + N_LINKS/2) mod N_LINKS. This is for arrival links 0 to N_LINKS-1.
- R6: Packet age is (now_phase - stamp) mod 4. A packet of age 2 or 3 is consumed (`in_ready`=1) with neither output valid, and the error counter does not change. Ages 0 and 1 are routed.
- R7: A packet with bad parity is consumed with neither output valid. The error counter rises by one for each such packet and holds at its all-ones maximum.
- R8: A healthy packet of kind other than multicast raises `byp_valid`, and then `in_ready` equals `byp_ready`. `mc_valid` and `byp_valid` are never high together.
- R9: A healthy multicast packet raises `mc_valid` and `in_ready` only when every bit set in `mc_dest` has its `dest_ready` bit set. Otherwise both stay low.
- R10: A write with `tbl_we` stores the value, mask, route and valid bit at `tbl_addr` on the clock edge. It acts on lookups from the next cycle. Reset clears all valid bits, so every multicast packet misses until an entry is written.
- R11: `out_hdr`, `out_key` and `out_payload` always carry the input fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_phase | input | 2 | Current time phase of the node |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet consumed this cycle |
| in_hdr | input | 8 | Packet header |
| in_key | input | KEY_W | Routing key |
| in_payload | input | KEY_W | Payload word |
| in_link | input | $clog2(N_LINKS) | Link the packet arrived on |
| out_hdr | output | 8 | Header passed through |
| out_key | output | KEY_W | Key passed through |
| out_payload | output | KEY_W | Payload passed through |
| mc_valid | output | 1 | Multicast copies released |
| mc_dest | output | N_LINKS+N_CORES | Destination bitmap |
| dest_ready | input | N_LINKS+N_CORES | Per-destination ready |
| byp_valid | output | 1 | Non-multicast packet on bypass |
| byp_ready | input | 1 | Bypass sink ready |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(ENTRIES) | Entry index to write |
| tbl_entry_valid | input | 1 | Valid bit to store |
| tbl_value | input | KEY_W | Stored compare value |
| tbl_mask | input | KEY_W | Compare mask, 1 = compare |
| tbl_route | input | N_LINKS+N_CORES | Route bitmap to store |
| err_count | output | ERR_W | Saturating parity-drop count |

## Verification
The bench builds the router with a 16-entry table and a 3-bit error counter, and keeps six links and eighteen cores. The small table lets the bench fill every entry, including the highest index. It also lets overlapping entries meet often in random traffic. The narrow counter reaches its saturation point after seven bad packets. Random keys are mostly taken from stored entries with their don't-care bits scrambled. Together with random ready patterns and random phase gaps, this covers hit, miss, stale and stalled cases in one mix.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   localparam int HDR_W = 8;

   typedef enum logic [1:0] {
      PK_MCAST = 2'b00,
      PK_P2P   = 2'b01,
      PK_NBR   = 2'b10,
      PK_FIXED = 2'b11
   } pkt_kind_e;

   // header layout, msb first
   typedef struct packed {
      pkt_kind_e  kind;
      logic [1:0] stamp;
      logic [1:0] spare;
      logic       has_pl;
      logic       par;
   } hdr_t;

   localparam logic [1:0] MAX_AGE = 2'd1;

endpackage

// File: rtl/mcr_hdr_check.sv
module mcr_hdr_check
   import mcr_pkg::*;
#(
   parameter int KEY_W = 32
) (
   input  hdr_t             hdr,
   input  logic [KEY_W-1:0] key,
   input  logic [KEY_W-1:0] payload,
   input  logic [1:0]       now_phase,
   output pkt_kind_e        kind,
   output logic             par_err,
   output logic             stale
);

   logic [1:0] age;

   always_comb begin
      kind    = hdr.kind;
      par_err = (^hdr) ^ (^key) ^ (hdr.has_pl & (^payload));
      age     = now_phase - hdr.stamp;
      stale   = (age > MAX_AGE);
   end

endmodule

// File: rtl/mcr_tcam.sv
module mcr_tcam #(
   parameter int KEY_W   = 32,
   parameter int DEST_W  = 24,
   parameter int ENTRIES = 1024,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic              wr_valid,
   input  logic [KEY_W-1:0]  wr_value,
   input  logic [KEY_W-1:0]  wr_mask,
   input  logic [DEST_W-1:0] wr_route,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              lk_hit,
   output logic [DEST_W-1:0] lk_route
);

   logic [KEY_W-1:0]   val_q [ENTRIES];
   logic [KEY_W-1:0]   msk_q [ENTRIES];
   logic [DEST_W-1:0]  rte_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] hit_vec;
   logic [IDX_W-1:0]   win_idx;
   logic               addr_ok;

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2
         assign addr_ok = 1'b1;
      end else begin : g_partial
         assign addr_ok = (wr_addr < IDX_W'(ENTRIES));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en && addr_ok) begin
         val_q[wr_addr] <= wr_value;
         msk_q[wr_addr] <= wr_mask;
         rte_q[wr_addr] <= wr_route;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en && addr_ok) begin
         vld_q[wr_addr] <= wr_valid;
      end
   end

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign hit_vec[e] = vld_q[e] & (((lk_key ^ val_q[e]) & msk_q[e]) == '0);
      end
   endgenerate

   // lowest index wins
   always_comb begin
      lk_hit  = 1'b0;
      win_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) begin
            lk_hit  = 1'b1;
            win_idx = IDX_W'(e);
         end
      end
      lk_route = rte_q[win_idx];
   end

endmodule

// File: rtl/mcr_fanout.sv
module mcr_fanout #(
   parameter int N_LINKS = 6,
   parameter int N_CORES = 18,
   localparam int DEST_W = N_LINKS + N_CORES,
   localparam int LINK_W = $clog2(N_LINKS)
) (
   input  logic              in_valid,
   input  logic              drop,
   input  logic              is_mc,
   input  logic              lk_hit,
   input  logic [DEST_W-1:0] lk_route,
   input  logic [LINK_W-1:0] in_link,
   input  logic [DEST_W-1:0] dest_ready,
   input  logic              byp_ready,
   output logic              mc_valid,
   output logic [DEST_W-1:0] mc_dest,
   output logic              byp_valid,
   output logic              in_ready
);

   localparam int HALF = N_LINKS / 2;

   logic [LINK_W:0]   turn_sum;
   logic [LINK_W-1:0] far_link;
   logic [DEST_W-1:0] miss_dest;
   logic              all_rdy;

   always_comb begin
      turn_sum = {1'b0, in_link} + (LINK_W + 1)'(HALF);
      if (turn_sum >= (LINK_W + 1)'(N_LINKS)) begin
         far_link = LINK_W'(turn_sum - (LINK_W + 1)'(N_LINKS));
      end else begin
         far_link = LINK_W'(turn_sum);
      end
      miss_dest = DEST_W'(1) << far_link;
      mc_dest   = lk_hit ? lk_route : miss_dest;
      all_rdy   = ((mc_dest & ~dest_ready) == '0);
      mc_valid  = in_valid & ~drop & is_mc & all_rdy;
      byp_valid = in_valid & ~drop & ~is_mc;
      in_ready  = drop | (is_mc ? all_rdy : byp_ready);
   end

endmodule

// File: rtl/mcr_router.sv
module mcr_router
   import mcr_pkg::*;
#(
   parameter int KEY_W   = 32,
   parameter int N_LINKS = 6,
   parameter int N_CORES = 18,
   parameter int ENTRIES = 1024,
   parameter int ERR_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 now_phase,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [7:0]                 in_hdr,
   input  logic [KEY_W-1:0]           in_key,
   input  logic [KEY_W-1:0]           in_payload,
   input  logic [$clog2(N_LINKS)-1:0] in_link,
   output logic [7:0]                 out_hdr,
   output logic [KEY_W-1:0]           out_key,
   output logic [KEY_W-1:0]           out_payload,
   output logic                       mc_valid,
   output logic [N_LINKS+N_CORES-1:0] mc_dest,
   input  logic [N_LINKS+N_CORES-1:0] dest_ready,
   output logic                       byp_valid,
   input  logic                       byp_ready,
   input  logic                       tbl_we,
   input  logic [$clog2(ENTRIES)-1:0] tbl_addr,
   input  logic                       tbl_entry_valid,
   input  logic [KEY_W-1:0]           tbl_value,
   input  logic [KEY_W-1:0]           tbl_mask,
   input  logic [N_LINKS+N_CORES-1:0] tbl_route,
   output logic [ERR_W-1:0]           err_count
);

   localparam int DEST_W = N_LINKS + N_CORES;

   generate
      if (N_LINKS < 2 || (N_LINKS % 2) != 0) begin : g_bad_links
         $error("mcr_router: N_LINKS must be even and at least 2");
      end
      if (ENTRIES < 2) begin : g_bad_entries
         $error("mcr_router: ENTRIES must be at least 2");
      end
      if (KEY_W < 1 || ERR_W < 1 || N_CORES < 0) begin : g_bad_width
         $error("mcr_router: KEY_W and ERR_W must be positive");
      end
      if (HDR_W != 8) begin : g_bad_hdr
         $error("mcr_router: header must be 8 bits");
      end
   endgenerate

   hdr_t              hdr;
   pkt_kind_e         kind;
   logic              par_err;
   logic              stale;
   logic              lk_hit;
   logic [DEST_W-1:0] lk_route;
   logic [ERR_W-1:0]  err_q;

   assign hdr = hdr_t'(in_hdr);

   mcr_hdr_check #(.KEY_W(KEY_W)) u_hdr (
      .hdr       (hdr),
      .key       (in_key),
      .payload   (in_payload),
      .now_phase (now_phase),
      .kind      (kind),
      .par_err   (par_err),
      .stale     (stale)
   );

   mcr_tcam #(
      .KEY_W   (KEY_W),
      .DEST_W  (DEST_W),
      .ENTRIES (ENTRIES)
   ) u_tcam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_addr  (tbl_addr),
      .wr_valid (tbl_entry_valid),
      .wr_value (tbl_value),
      .wr_mask  (tbl_mask),
      .wr_route (tbl_route),
      .lk_key   (in_key),
      .lk_hit   (lk_hit),
      .lk_route (lk_route)
   );

   mcr_fanout #(
      .N_LINKS (N_LINKS),
      .N_CORES (N_CORES)
   ) u_fan (
      .in_valid   (in_valid),
      .drop       (par_err | stale),
      .is_mc      (kind == PK_MCAST),
      .lk_hit     (lk_hit),
      .lk_route   (lk_route),
      .in_link    (in_link),
      .dest_ready (dest_ready),
      .byp_ready  (byp_ready),
      .mc_valid   (mc_valid),
      .mc_dest    (mc_dest),
      .byp_valid  (byp_valid),
      .in_ready   (in_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
      end else if (in_valid && par_err && (err_q != {ERR_W{1'b1}})) begin
         err_q <= err_q + 1'b1;
      end
   end

   assign err_count   = err_q;
   assign out_hdr     = in_hdr;
   assign out_key     = in_key;
   assign out_payload = in_payload;

endmodule

// File: rtl/mcr_router_chk.sv
module mcr_router_chk #(
   parameter int N_LINKS = 6,
   parameter int DEST_W  = 24,
   parameter int ERR_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              mc_valid,
   input logic [DEST_W-1:0] mc_dest,
   input logic [DEST_W-1:0] dest_ready,
   input logic              byp_valid,
   input logic              byp_ready,
   input logic              par_err,
   input logic              stale,
   input logic              lk_hit,
   input logic [ERR_W-1:0]  err_count
);

   AST_MC_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mc_valid |-> ((mc_dest & ~dest_ready) == '0)); // R9

   AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      !(mc_valid && byp_valid)); // R8

   AST_BYP_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      byp_valid |-> (in_ready == byp_ready)); // R8

   AST_STALE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stale) |-> (in_ready && !mc_valid && !byp_valid)); // R6

   AST_PARITY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && par_err) |-> (in_ready && !mc_valid && !byp_valid)); // R7

   AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && par_err && (err_count != {ERR_W{1'b1}}))
      |=> (err_count == $past(err_count) + 1'b1)); // R7

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && par_err) |=> $stable(err_count)); // R7

   AST_MISS_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_valid && !lk_hit) |->
      (($countones(mc_dest[N_LINKS-1:0]) == 1) && (mc_dest[DEST_W-1:N_LINKS] == '0))); // R5

endmodule

bind mcr_router mcr_router_chk #(
   .N_LINKS (N_LINKS),
   .DEST_W  (DEST_W),
   .ERR_W   (ERR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .mc_valid   (mc_valid),
   .mc_dest    (mc_dest),
   .dest_ready (dest_ready),
   .byp_valid  (byp_valid),
   .byp_ready  (byp_ready),
   .par_err    (par_err),
   .stale      (stale),
   .lk_hit     (lk_hit),
   .err_count  (err_count)
);

// File: tb/mcr_router_test.sv
`timescale 1ns/1ps
module mcr_router_test;

   localparam int KEY_W   = 32;
   localparam int N_LINKS = 6;
   localparam int N_CORES = 18;
   localparam int ENTRIES = 16;
   localparam int ERR_W   = 3;
   localparam int DEST_W  = N_LINKS + N_CORES;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        now_phase = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [7:0]        in_hdr = '0;
   logic [KEY_W-1:0]  in_key = '0;
   logic [KEY_W-1:0]  in_payload = '0;
   logic [2:0]        in_link = '0;
   logic [7:0]        out_hdr;
   logic [KEY_W-1:0]  out_key;
   logic [KEY_W-1:0]  out_payload;
   logic              mc_valid;
   logic [DEST_W-1:0] mc_dest;
   logic [DEST_W-1:0] dest_ready = '1;
   logic              byp_valid;
   logic              byp_ready = 1'b1;
   logic              tbl_we = 1'b0;
   logic [3:0]        tbl_addr = '0;
   logic              tbl_entry_valid = 1'b0;
   logic [KEY_W-1:0]  tbl_value = '0;
   logic [KEY_W-1:0]  tbl_mask = '0;
   logic [DEST_W-1:0] tbl_route = '0;
   logic [ERR_W-1:0]  err_count;

   always #2 clk = ~clk;

   mcr_router #(
      .KEY_W(KEY_W), .N_LINKS(N_LINKS), .N_CORES(N_CORES),
      .ENTRIES(ENTRIES), .ERR_W(ERR_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .now_phase(now_phase),
      .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
      .in_key(in_key), .in_payload(in_payload), .in_link(in_link),
      .out_hdr(out_hdr), .out_key(out_key), .out_payload(out_payload),
      .mc_valid(mc_valid), .mc_dest(mc_dest), .dest_ready(dest_ready),
      .byp_valid(byp_valid), .byp_ready(byp_ready),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_entry_valid(tbl_entry_valid),
      .tbl_value(tbl_value), .tbl_mask(tbl_mask), .tbl_route(tbl_route),
      .err_count(err_count)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // reference table
   logic [KEY_W-1:0]  m_val [ENTRIES];
   logic [KEY_W-1:0]  m_msk [ENTRIES];
   logic [DEST_W-1:0] m_rte [ENTRIES];
   logic [ENTRIES-1:0] m_vld = '0;
   int m_err = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // header with correct parity (R1)
   function automatic logic [7:0] mk_hdr(input logic [1:0] kind, input logic [1:0] ts,
                                         input logic pl, input logic [KEY_W-1:0] key,
                                         input logic [KEY_W-1:0] pay, input bit bad);
      logic [7:0] h;
      h = {kind, ts, 2'b00, pl, 1'b0};
      h[0] = (^h) ^ (^key) ^ (pl & (^pay)) ^ bad;
      return h;
   endfunction

   function automatic logic [DEST_W-1:0] exp_dest(input logic [KEY_W-1:0] key, input logic [2:0] lnk);
      for (int e = 0; e < ENTRIES; e++) begin
         if (m_vld[e] && (((key ^ m_val[e]) & m_msk[e]) == '0)) return m_rte[e];
      end
      return DEST_W'(1) << ((int'(lnk) + N_LINKS / 2) % N_LINKS);
   endfunction

   task automatic wr_entry(input int idx, input logic v, input logic [KEY_W-1:0] val,
                           input logic [KEY_W-1:0] msk, input logic [DEST_W-1:0] rte);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 4'(idx); tbl_entry_valid = v;
      tbl_value = val; tbl_mask = msk; tbl_route = rte;
      @(negedge clk);
      tbl_we = 1'b0;
      m_vld[idx] = v; m_val[idx] = val; m_msk[idx] = msk; m_rte[idx] = rte;
   endtask

   // drive one packet for one cycle and check every output
   task automatic send(input string req, input logic [7:0] h, input logic [KEY_W-1:0] key,
                       input logic [KEY_W-1:0] pay, input logic [2:0] lnk,
                       input logic [DEST_W-1:0] drdy, input logic brdy);
      logic perr, stale, drop, is_mc, allr, e_mc, e_byp, e_rdy;
      logic [1:0] age;
      logic [DEST_W-1:0] d;
      @(negedge clk);
      in_valid = 1'b1; in_hdr = h; in_key = key; in_payload = pay; in_link = lnk;
      dest_ready = drdy; byp_ready = brdy;
      #1;
      perr  = (^h) ^ (^key) ^ (h[1] & (^pay));
      age   = now_phase - h[5:4];
      stale = (age >= 2'd2);
      drop  = perr | stale;
      is_mc = (h[7:6] == 2'b00);
      d     = exp_dest(key, lnk);
      allr  = ((d & ~drdy) == '0);
      e_mc  = !drop && is_mc && allr;
      e_byp = !drop && !is_mc;
      e_rdy = drop || (is_mc ? allr : brdy);
      chk(mc_valid == e_mc, req, 64'(mc_valid), 64'(e_mc));
      chk(byp_valid == e_byp, req, 64'(byp_valid), 64'(e_byp));
      chk(in_ready == e_rdy, req, 64'(in_ready), 64'(e_rdy));
      if (e_mc) chk(mc_dest == d, req, 64'(mc_dest), 64'(d));
      chk({out_hdr, out_key, out_payload} == {h, key, pay}, "R11", 64'(out_key), 64'(key));
      if (perr && m_err < (1 << ERR_W) - 1) m_err++;
      @(negedge clk);
      in_valid = 1'b0;
      chk(int'(err_count) == m_err, "R7 counter", 64'(err_count), 64'(m_err));
   endtask

   logic [KEY_W-1:0] rk, rp;

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // reset state
      chk(mc_valid == 1'b0, "R10 reset mc_valid", 64'(mc_valid), 0);
      chk(byp_valid == 1'b0, "R10 reset byp_valid", 64'(byp_valid), 0);
      chk(err_count == '0, "R7 reset count", 64'(err_count), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: empty table misses; R5 default link
      send("R10 empty table miss", mk_hdr(2'b00, 2'd0, 1'b0, 32'h1234, 32'h0, 0), 32'h1234, 32'h0, 3'd1, '1, 1'b1);

      // R2 / R3 / R4
      wr_entry(0, 1'b1, 32'h0000_1200, 32'h0000_FF00, 24'h000041);
      wr_entry(1, 1'b1, 32'h0000_1234, 32'hFFFF_FFFF, 24'h800002);
      send("R3 lowest index wins", mk_hdr(2'b00, 2'd0, 1'b0, 32'h1234, 0, 0), 32'h0000_1234, 32'h0, 3'd0, '1, 1'b1);
      send("R2 dont care bits", mk_hdr(2'b00, 2'd0, 1'b0, 32'h00AB_12FF, 0, 0), 32'h00AB_12FF, 32'h0, 3'd0, '1, 1'b1);
      send("R2 compared bit differs", mk_hdr(2'b00, 2'd0, 1'b0, 32'h0000_1334, 0, 0), 32'h0000_1334, 32'h0, 3'd2, '1, 1'b1);
      wr_entry(0, 1'b0, 32'h0000_1200, 32'h0000_FF00, 24'h000041);
      send("R10 invalidated entry", mk_hdr(2'b00, 2'd0, 1'b0, 32'h1234, 0, 0), 32'h0000_1234, 32'h0, 3'd0, '1, 1'b1);
      wr_entry(15, 1'b1, 32'hCAFE_0000, 32'hFFFF_FFFF, 24'hFFFFFF);
      send("R4 last entry all outputs", mk_hdr(2'b00, 2'd0, 1'b0, 32'hCAFE_0000, 0, 0), 32'hCAFE_0000, 32'h0, 3'd3, '1, 1'b1);
      send("R9 one destination busy", mk_hdr(2'b00, 2'd0, 1'b0, 32'hCAFE_0000, 0, 0), 32'hCAFE_0000, 32'h0, 3'd3, 24'hFFFBFF, 1'b1);
      send("R9 miss link busy", mk_hdr(2'b00, 2'd0, 1'b0, 32'h0BAD_0000, 0, 0), 32'h0BAD_0000, 32'h0, 3'd0, 24'hFFFFF7, 1'b1);

      // R5: every arrival link
      for (int l = 0; l < N_LINKS; l++)
         send("R5 opposite link", mk_hdr(2'b00, 2'd0, 1'b0, 32'h5555_0000, 0, 0), 32'h5555_0000, 32'h0, 3'(l), '1, 1'b1);

      // R6: ages 0..3
      now_phase = 2'd0;
      for (int t = 0; t < 4; t++)
         send("R6 age window", mk_hdr(2'b00, 2'(t), 1'b0, 32'hCAFE_0000, 0, 0), 32'hCAFE_0000, 32'h0, 3'd0, '1, 1'b1);

      // R8: bypass kinds with sink busy and free
      for (int k = 1; k < 4; k++) begin
         send("R8 bypass sink busy", mk_hdr(2'(k), 2'd0, 1'b1, 32'h77, 32'h99, 0), 32'h77, 32'h99, 3'd2, '1, 1'b0);
         send("R8 bypass sink free", mk_hdr(2'(k), 2'd0, 1'b1, 32'h77, 32'h99, 0), 32'h77, 32'h99, 3'd2, '1, 1'b1);
      end

      // R1: payload ignored when flag clear, counted when set
      send("R1 payload unflagged", mk_hdr(2'b00, 2'd0, 1'b0, 32'hCAFE_0000, 32'h0, 0), 32'hCAFE_0000, 32'h0000_0001, 3'd0, '1, 1'b1);
      send("R1 payload flagged", mk_hdr(2'b00, 2'd0, 1'b1, 32'hCAFE_0000, 32'h1, 0), 32'hCAFE_0000, 32'h0000_0001, 3'd0, '1, 1'b1);

      // R7: bad parity until saturation
      for (int b = 0; b < 9; b++)
         send("R7 parity drop", mk_hdr(2'(b % 4), 2'd0, 1'b0, 32'h42, 0, 1), 32'h42, 32'h0, 3'd1, '1, 1'b1);

      // random table and traffic
      for (int e = 0; e < ENTRIES; e++)
         wr_entry(e, 1'($urandom % 4 != 0), $urandom, $urandom | $urandom, 24'($urandom));
      for (int n = 0; n < 400; n++) begin
         int pick;
         pick = $urandom % ENTRIES;
         rk = $urandom;
         if ($urandom % 4 != 0) rk = (m_val[pick] & m_msk[pick]) | (rk & ~m_msk[pick]);
         rp = $urandom;
         now_phase = 2'($urandom);
         send("R2 R3 R9 random", mk_hdr(2'($urandom % 5 == 0 ? $urandom : 0), 2'($urandom),
                                        1'($urandom), rk, rp, ($urandom % 10) == 0),
              rk, rp, 3'($urandom % N_LINKS),
              ($urandom % 2 == 0) ? '1 : DEST_W'($urandom | $urandom), 1'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule